// File: doc/BRIEF.md
# Processor Mode and Banked Stack Pointer Unit

This unit keeps track of whether a small processor core is servicing an exception (handler mode) or running ordinary code (thread mode), and at which privilege level thread code runs. It holds a 2-bit mode-control register, two banked stack pointers (a main one and a process one) and a program counter register. It presents the stack pointer that the current mode selects as the single active stack pointer.

Exception entry and return arrive as one-cycle strobes from the core's sequencer. Register accesses arrive as write and read requests, each tagged with a 3-bit register select. Explicit access to the banked stack pointers and to the mode-control register is reserved for privileged code. An unprivileged attempt on them is refused and produces a one-clock fault pulse. The unit also forces the alignment rules: stack pointers are always word aligned and the program counter is always halfword aligned.

Top module: `mode_stack_unit`

## Requirements
- R1: After reset the unit is in privileged thread mode (`handler_o`=0, `user_o`=0) on the main stack. `sp_o` equals `rst_msp_i` with bits [1:0] cleared, `pc_o` is 0 and `fault_o` is 0.
- R2: An `exc_enter_i` strobe puts the unit in handler mode from the next cycle on, whatever the mode it was in. Handler mode is privileged, and `sp_o` shows the main stack pointer there even when control bit 1 is set.
- R3: An `exc_return_i` strobe in handler mode returns the unit to thread mode. The stored control bits then select the level and the stack again. An `exc_return_i` strobe in thread mode has no effect.
- R4: Control bit 0 gives the thread level (0 privileged, 1 user). Control bit 1 gives the thread stack (0 main, 1 process). A read of the control register (select 3) returns bit 1 as 0 in handler mode. A handler-mode write to it updates bit 0 only.
- R5: The register selects are 0 active SP, 1 main SP, 2 process SP, 3 control and 4 PC. A write to select 0 updates whichever bank is active. Selects 5 to 7 read as 0, are ignored on write and never fault.
- R6: Bits [1:0] of both stack pointers are always 0. This holds after reset loads and after every write.
- R7: Bit 0 of the program counter is always 0 after a write.
- R8: In user level, a read or write of select 1, 2 or 3 raises `fault_o` in the next cycle. Such a write changes nothing, and such a read returns 0.
- R9: `fault_o` is high for exactly the cycle after each refused request and low after legal requests, including accesses to selects 0, 4 and 5 to 7.
- R10: A write in the same cycle as an entry or return strobe is dropped. When both strobes arrive together, entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rst_msp_i | input | W | Reset load value for the main stack pointer |
| rst_psp_i | input | W | Reset load value for the process stack pointer |
| exc_enter_i | input | 1 | Exception entry strobe |
| exc_return_i | input | 1 | Exception return strobe |
| wr_en_i | input | 1 | Register write request |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | W | Write data |
| rd_en_i | input | 1 | Register read request |
| rd_sel_i | input | 3 | Register select for the read |
| rd_data_o | output | W | Read data, same cycle as the request |
| handler_o | output | 1 | 1 while in handler mode |
| user_o | output | 1 | 1 while running at user level |
| sp_o | output | W | Active stack pointer value |
| pc_o | output | W | Program counter value |
| fault_o | output | 1 | One-cycle pulse after a refused access |

## Verification
The hardest state to reach is user-level thread mode on the process stack with a handler-mode control write pending behind it. Privileged code can enter user level, but the only way back to privilege is through an exception. The stimulus therefore sets the process stack from privileged thread code, takes an entry strobe, rewrites control bit 0 while in handler mode, and then returns. It also probes writes that coincide with entry and return strobes, and a long random phase drives strobes often enough to cycle through all three states many times.

// File: rtl/modestk_pkg.sv
package modestk_pkg;
  typedef enum logic [2:0] {
    SEL_SP   = 3'd0,
    SEL_MSP  = 3'd1,
    SEL_PSP  = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_PC   = 3'd4
  } regsel_e;

  // explicit banked-SP and control accesses are reserved for privileged code
  function automatic logic sel_guarded(input logic [2:0] sel);
    return (sel == SEL_MSP) || (sel == SEL_PSP) || (sel == SEL_CTRL);
  endfunction
endpackage

// File: rtl/modestk_mode_ctrl.sv
module modestk_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_i,
  input  logic       return_i,
  input  logic       ctrl_we_i,
  input  logic [1:0] ctrl_wdata_i,
  output logic       handler_o,
  output logic       level_bit_o,
  output logic       user_o,
  output logic       spsel_o,
  output logic       return_evt_o
);
  logic       handler_q;
  logic [1:0] ctrl_q;

  assign return_evt_o = return_i && !enter_i && handler_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      handler_q <= 1'b0;
      ctrl_q    <= 2'b00;
    end else begin
      if (enter_i)
        handler_q <= 1'b1;
      else if (return_evt_o)
        handler_q <= 1'b0;
      if (ctrl_we_i) begin
        ctrl_q[0] <= ctrl_wdata_i[0];
        if (!handler_q)
          ctrl_q[1] <= ctrl_wdata_i[1];
      end
    end
  end

  assign handler_o   = handler_q;
  assign level_bit_o = ctrl_q[0];
  assign user_o      = !handler_q && ctrl_q[0];
  assign spsel_o     = !handler_q && ctrl_q[1];
endmodule

// File: rtl/modestk_access_guard.sv
module modestk_access_guard
  import modestk_pkg::*;
(
  input  logic       user_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic       rd_en_i,
  input  logic [2:0] rd_sel_i,
  output logic       illegal_o
);
  logic wr_bad, rd_bad;
  assign wr_bad    = wr_en_i && sel_guarded(wr_sel_i);
  assign rd_bad    = rd_en_i && sel_guarded(rd_sel_i);
  assign illegal_o = user_i && (wr_bad || rd_bad);
endmodule

// File: rtl/modestk_stack_bank.sv
module modestk_stack_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_msp_i,
  input  logic [W-1:0] rst_psp_i,
  input  logic         spsel_i,
  input  logic         sp_we_i,
  input  logic         msp_we_i,
  input  logic         psp_we_i,
  input  logic         pc_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] msp_o,
  output logic [W-1:0] psp_o,
  output logic [W-1:0] active_o,
  output logic [W-1:0] pc_o
);
  localparam int unsigned NBANK = 2;
  localparam logic [W-1:0] WORD_MASK = ~W'(3);
  localparam logic [W-1:0] HALF_MASK = ~W'(1);

  function automatic logic [W-1:0] align_word(input logic [W-1:0] v);
    return v & WORD_MASK;
  endfunction

  function automatic logic [W-1:0] align_half(input logic [W-1:0] v);
    return v & HALF_MASK;
  endfunction

  logic [W-1:0] bank_q   [NBANK];
  logic [W-1:0] bank_rst [NBANK];
  logic         bank_we  [NBANK];
  logic         expl_we  [NBANK];
  logic [W-1:0] pc_q;

  assign bank_rst[0] = rst_msp_i;
  assign bank_rst[1] = rst_psp_i;
  assign expl_we[0]  = msp_we_i;
  assign expl_we[1]  = psp_we_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b] = expl_we[b] || (sp_we_i && (spsel_i == b[0]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[b] <= align_word(bank_rst[b]);
      else if (bank_we[b])
        bank_q[b] <= align_word(wdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= '0;
    else if (pc_we_i)
      pc_q <= align_half(wdata_i);
  end

  assign msp_o    = bank_q[0];
  assign psp_o    = bank_q[1];
  assign active_o = spsel_i ? bank_q[1] : bank_q[0];
  assign pc_o     = pc_q;
endmodule

// File: rtl/mode_stack_unit.sv
module mode_stack_unit
  import modestk_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_msp_i,
  input  logic [W-1:0] rst_psp_i,
  input  logic         exc_enter_i,
  input  logic         exc_return_i,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  input  logic [2:0]   rd_sel_i,
  output logic [W-1:0] rd_data_o,
  output logic         handler_o,
  output logic         user_o,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] pc_o,
  output logic         fault_o
);
  logic         illegal_w;
  logic         exc_evt_w;
  logic         wr_ok_w;
  logic         spsel_w;
  logic         level_bit_w;
  logic         return_evt_w;
  logic [W-1:0] msp_w, psp_w, active_w;
  logic         fault_q;

  assign exc_evt_w = exc_enter_i || exc_return_i;
  assign wr_ok_w   = wr_en_i && !illegal_w && !exc_evt_w;

  modestk_access_guard u_guard (
    .user_i    (user_o),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .illegal_o (illegal_w)
  );

  modestk_mode_ctrl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_i      (exc_enter_i),
    .return_i     (exc_return_i),
    .ctrl_we_i    (wr_ok_w && (wr_sel_i == SEL_CTRL)),
    .ctrl_wdata_i (wr_data_i[1:0]),
    .handler_o    (handler_o),
    .level_bit_o  (level_bit_w),
    .user_o       (user_o),
    .spsel_o      (spsel_w),
    .return_evt_o (return_evt_w)
  );

  modestk_stack_bank #(.W(W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_msp_i (rst_msp_i),
    .rst_psp_i (rst_psp_i),
    .spsel_i   (spsel_w),
    .sp_we_i   (wr_ok_w && (wr_sel_i == SEL_SP)),
    .msp_we_i  (wr_ok_w && (wr_sel_i == SEL_MSP)),
    .psp_we_i  (wr_ok_w && (wr_sel_i == SEL_PSP)),
    .pc_we_i   (wr_ok_w && (wr_sel_i == SEL_PC)),
    .wdata_i   (wr_data_i),
    .msp_o     (msp_w),
    .psp_o     (psp_w),
    .active_o  (active_w),
    .pc_o      (pc_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= illegal_w;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i && !illegal_w) begin
      case (rd_sel_i)
        SEL_SP:   rd_data_o = active_w;
        SEL_MSP:  rd_data_o = msp_w;
        SEL_PSP:  rd_data_o = psp_w;
        SEL_CTRL: rd_data_o = {{(W-2){1'b0}}, spsel_w, level_bit_w};
        SEL_PC:   rd_data_o = pc_o;
        default:  rd_data_o = '0;
      endcase
    end
  end

  assign sp_o    = active_w;
  assign fault_o = fault_q;
endmodule

// File: rtl/modestk_chk.sv
module modestk_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exc_enter_i,
  input logic         exc_return_i,
  input logic         rd_en_i,
  input logic [2:0]   rd_sel_i,
  input logic [W-1:0] rd_data_o,
  input logic         handler_o,
  input logic         user_o,
  input logic [W-1:0] sp_o,
  input logic [W-1:0] pc_o,
  input logic         fault_o,
  input logic         illegal_w,
  input logic         return_evt_w
);
  // R2
  enter_to_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter_i |=> (handler_o && !user_o));

  // R3
  stray_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return_i && !exc_enter_i && !handler_o) |=> !handler_o);

  // R3
  return_to_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    return_evt_w |=> !handler_o);

  // R4
  handler_ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_sel_i == 3'd3 && handler_o) |-> (rd_data_o[1] == 1'b0));

  // R6
  sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_o[1:0] == 2'b00);

  // R7
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[0] == 1'b0);

  // R8
  refused_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_w |=> fault_o);

  // R8
  refused_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_w && !exc_enter_i && !exc_return_i) |=>
      ($stable(sp_o) && $stable(pc_o) && $stable(handler_o) && $stable(user_o)));

  // R9
  no_spurious_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_w |=> !fault_o);
endmodule

bind mode_stack_unit modestk_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_enter_i  (exc_enter_i),
  .exc_return_i (exc_return_i),
  .rd_en_i      (rd_en_i),
  .rd_sel_i     (rd_sel_i),
  .rd_data_o    (rd_data_o),
  .handler_o    (handler_o),
  .user_o       (user_o),
  .sp_o         (sp_o),
  .pc_o         (pc_o),
  .fault_o      (fault_o),
  .illegal_w    (illegal_w),
  .return_evt_w (return_evt_w)
);

// File: tb/sim_mode_stack_unit.sv
module sim_mode_stack_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] rst_msp = 32'h2000_0FFF;
  logic [W-1:0] rst_psp = 32'h1000_0802;
  logic ee = 0, er = 0, we = 0, re = 0;
  logic [2:0] ws = 0, rs = 0;
  logic [W-1:0] wd = 0;
  logic [W-1:0] rd_data, sp, pc;
  logic handler, user, fault;

  mode_stack_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_msp_i(rst_msp), .rst_psp_i(rst_psp),
    .exc_enter_i(ee), .exc_return_i(er),
    .wr_en_i(we), .wr_sel_i(ws), .wr_data_i(wd),
    .rd_en_i(re), .rd_sel_i(rs), .rd_data_o(rd_data),
    .handler_o(handler), .user_o(user), .sp_o(sp), .pc_o(pc), .fault_o(fault)
  );

  int checks = 0;
  int fails = 0;
  string req = "R1";
  bit done = 0;

  // behavioural reference state
  bit m_h = 0, m_lvl = 0, m_stk = 0, m_f = 0;
  logic [31:0] m_msp = 32'h2000_0FFC;
  logic [31:0] m_psp = 32'h1000_0800;
  logic [31:0] m_pc = 0;

  function automatic bit m_user();
    return !m_h && m_lvl;
  endfunction

  function automatic bit special(input logic [2:0] s);
    return (s == 1) || (s == 2) || (s == 3);
  endfunction

  function automatic bit m_refused();
    return m_user() && ((we && special(ws)) || (re && special(rs)));
  endfunction

  function automatic bit on_psp();
    return !m_h && m_stk;
  endfunction

  function automatic logic [31:0] m_read();
    if (!re || m_refused()) return 0;
    case (rs)
      0: return on_psp() ? m_psp : m_msp;
      1: return m_msp;
      2: return m_psp;
      3: return {30'd0, on_psp(), m_lvl};
      4: return m_pc;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string sig, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, sig, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("handler_o", {31'd0, handler}, {31'd0, m_h});
    chk("user_o", {31'd0, user}, {31'd0, m_user()});
    chk("sp_o", sp, on_psp() ? m_psp : m_msp);
    chk("pc_o", pc, m_pc);
    chk("fault_o", {31'd0, fault}, {31'd0, m_f});
    chk("rd_data_o", rd_data, m_read());
  endtask

  task automatic model_step();
    bit bad;
    if (!rst_n) begin
      m_h = 0; m_lvl = 0; m_stk = 0; m_f = 0; m_pc = 0;
      m_msp = rst_msp & ~32'd3;
      m_psp = rst_psp & ~32'd3;
      return;
    end
    bad = m_refused();
    if (ee) m_h = 1;
    else if (er && m_h) m_h = 0;
    else if (we && !bad && !er) begin
      case (ws)
        0: if (on_psp()) m_psp = wd & ~32'd3; else m_msp = wd & ~32'd3;
        1: m_msp = wd & ~32'd3;
        2: m_psp = wd & ~32'd3;
        3: begin
          m_lvl = wd[0];
          if (!m_h) m_stk = wd[1];
        end
        4: m_pc = wd & ~32'd1;
        default: ;
      endcase
    end
    m_f = bad;
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    #0 model_step();
    @(negedge clk);
  endtask

  task automatic drive(input bit e_in, input bit r_in, input bit w_en, input logic [2:0] w_s,
                       input logic [31:0] w_d, input bit r_en, input logic [2:0] r_s);
    ee = e_in; er = r_in; we = w_en; ws = w_s; wd = w_d; re = r_en; rs = r_s;
    cyc();
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    drive(0, 0, 1, s, d, 0, 0);
  endtask

  task automatic rd(input logic [2:0] s);
    drive(0, 0, 0, 0, 0, 1, s);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state while held, then released
    req = "R1";
    repeat (2) cyc();
    rst_n = 1'b1;
    idle();
    rd(0);
    // R6: misaligned explicit main-stack write
    req = "R6";
    wr(1, 32'h2000_1237);
    rd(0);
    // R5: process stack write, switch to it, write through active select
    req = "R5";
    wr(2, 32'h1000_4005);
    wr(3, 32'h2);
    rd(0);
    wr(0, 32'h1000_3ABF);
    rd(2);
    rd(1);
    // R7: odd program counter
    req = "R7";
    wr(4, 32'h0000_1235);
    rd(4);
    // R2: entry forces main stack
    req = "R2";
    drive(1, 0, 0, 0, 0, 0, 0);
    rd(0);
    // R4: handler control view and write
    req = "R4";
    rd(3);
    wr(3, 32'h1);
    rd(3);
    wr(0, 32'h2000_2003);
    // R3: return to user thread on process stack, stray return
    req = "R3";
    drive(0, 1, 0, 0, 0, 0, 0);
    rd(0);
    drive(0, 1, 0, 0, 0, 0, 0);
    idle();
    // R8: refused user accesses
    req = "R8";
    rd(3);
    wr(1, 32'h1111_1111);
    wr(2, 32'h2222_2222);
    wr(3, 32'h0);
    rd(1);
    idle();
    // R9: legal user accesses and unused selects
    req = "R9";
    wr(0, 32'h1000_0101);
    rd(0);
    wr(5, 32'hFFFF_FFFF);
    rd(6);
    wr(4, 32'h0000_0042);
    drive(0, 0, 1, 7, 32'h5, 1, 2);
    idle();
    // R10: writes racing strobes, both strobes at once
    req = "R10";
    drive(1, 0, 1, 0, 32'h3000_0000, 0, 0);
    rd(1);
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(0, 1, 1, 4, 32'h0000_0777, 0, 0);
    rd(4);
    drive(1, 0, 0, 0, 0, 0, 0);
    wr(3, 32'h0);
    drive(0, 1, 0, 0, 0, 0, 0);
    wr(3, 32'h2);
    rd(3);
    // R5: random stress through all states
    req = "R5";
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom_range(0, 99);
      drive(r < 6, (r >= 6 && r < 12) || r == 3, $urandom_range(0, 1) == 1,
            3'($urandom_range(0, 7)), $urandom,
            $urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)));
    end
    idle();
    done = 1;
    summary();
    $finish;
  end
endmodule